// File: doc/BRIEF.md
# Configurable External Interrupt Forwarder

This block takes a bank of asynchronous external interrupt lines and forwards each one to an active-high, level-type output of the same index, ready for a downstream interrupt controller. Every line has its own trigger condition: it can be level-sensitive or edge-sensitive, and it can be active-high/rising or active-low/falling. A qualifying condition sets a sticky request bit. The request drives the output unless the line is masked. A masked line keeps latching requests, but its output stays low.

Software uses a simple word-addressed register bus to set the configuration and to clear requests. It clears a request with a write-one-to-clear register at the end of service. It also clears just before unmasking a line, so that any condition latched while the line was disabled is dropped. The block also holds a source-select word and a software-interrupt word as plain storage for software.

Top module: `xif_forwarder`

## Requirements
- R1: After reset the mask register reads all ones, the polarity register all ones, the edge-select, source-select and software-interrupt registers zero, all requests are clear and every output is low.
- R2: With edge-select bit 0 (level mode), a line whose synchronised input equals its polarity bit (1 = high active, 0 = low active) sets its request.
- R3: With edge-select bit 1 (edge mode), only a transition toward the polarity level (1 = rising, 0 = falling) sets the request. Holding the input at that level afterwards does not set it again.
- R4: A request stays set after its input goes inactive, until it is cleared.
- R5: Writing the clear register (word offset 0x10) clears each request whose data bit is 1. Bits written as 0 leave their requests unchanged. A clear takes priority over a trigger in the same cycle.
- R6: In level mode, if a request is cleared while the input is still active, the request reads 0 for one cycle and is set again on the next clock edge.
- R7: A mask bit of 1 forces that output low. The request is still latched and still visible in the raw status.
- R8: Masked status (0x08) and the output lines both equal raw status AND NOT mask.
- R9: The register map is: mask 0x00, source select 0x04, masked status 0x08, raw status 0x0C, clear 0x10, polarity 0x14, edge select 0x18, software interrupt 0x1C. The writable words read back what was written. Writes to the two status words are ignored. The clear word reads as zero. A misaligned address hits nothing.
- R10: An input change reaches the raw status on the third rising clock edge after it is applied: two synchroniser stages, then the request flop.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | NUM_LINES | Register write data |
| bus_rdata | output | NUM_LINES | Register read data, combinational from bus_addr |
| irq_out | output | NUM_LINES | Active-high level interrupt outputs |

## Verification
The bound checker checks several properties on every cycle:
- a masked line never drives its output;
- a trigger not overridden by a clear always leaves its request set;
- a clear always empties its requests;
- a request never disappears without a clear;
- a request never appears without a trigger;
- the reset values hold.

Some behaviours can only be shown by the bench scenarios. These are the exact trigger meaning of each edge/polarity combination, the three-edge input latency, the one-cycle dip of a level request cleared while still active, the register-map decoding, and the read-only status words. The bench sweeps all four trigger modes with distinct line patterns to cover them.

// File: rtl/xif_pkg.sv
// Shared definitions for the external interrupt forwarder.
// Assumes word-aligned byte addresses with 8 register words.
package xif_pkg;

    localparam int REG_IDX_W = 3;

    // Register word selector; the index is byte address bits [4:2].
    typedef enum logic [REG_IDX_W-1:0] {
        SEL_MASK  = 3'd0,
        SEL_SRC   = 3'd1,
        SEL_MSTAT = 3'd2,
        SEL_RSTAT = 3'd3,
        SEL_CLEAR = 3'd4,
        SEL_POL   = 3'd5,
        SEL_EDGE  = 3'd6,
        SEL_SWI   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/xif_sync.sv
// Multi-stage synchroniser for a bank of asynchronous inputs.
// Assumes STAGES >= 2; every stage resets to zero.
module xif_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/xif_detect.sv
// Per-line trigger detection and sticky request latch.
// Level mode: the input is at its polarity level.
// Edge mode: the input has just moved to its polarity level, judged
// against the previous synchronised sample.
// A clear beats a trigger in the same cycle.
module xif_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] req_q
);

    logic [WIDTH-1:0] prev_q;

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic at_level;
        logic moved;

        assign at_level = (sync_in[i] == pol[i]);
        assign moved    = (sync_in[i] != prev_q[i]);

        // Select the trigger condition for this line's mode.
        always_comb begin
            if (edge_sel[i]) trig[i] = at_level && moved;
            else             trig[i] = at_level;
        end

        // Latch the request; a clear has priority over a new trigger.
        always_ff @(posedge clk) begin
            if (!rst_n)       req_q[i] <= 1'b0;
            else if (clr[i])  req_q[i] <= 1'b0;
            else if (trig[i]) req_q[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/xif_regfile.sv
// Register file and read mux for the forwarder.
// Assumes ADDR_W >= 5 and byte addressing. Misaligned accesses or
// set upper bits hit nothing. Status words are read-only, and the
// clear word is write-one-to-clear and reads as zero.
module xif_regfile
    import xif_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  raw_req,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  pol_q,
    output logic [WIDTH-1:0]  edge_q,
    output logic [WIDTH-1:0]  clr_pulse,
    output logic [WIDTH-1:0]  masked,
    output logic [WIDTH-1:0]  rdata
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + REG_IDX_W - 1;

    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] swi_q;
    logic             upper_zero;
    logic             hit;
    reg_sel_e         sel;

    if (ADDR_W > IDX_HI + 1) begin : g_upper
        assign upper_zero = (addr[ADDR_W-1:IDX_HI+1] == '0);
    end else begin : g_noupper
        assign upper_zero = 1'b1;
    end

    assign sel = reg_sel_e'(addr[IDX_HI:IDX_LO]);
    assign hit = upper_zero && (addr[IDX_LO-1:0] == '0);

    // Hold the writable configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '1;
            edge_q <= '0;
            src_q  <= '0;
            swi_q  <= '0;
        end else if (wr && hit) begin
            case (sel)
                SEL_MASK: mask_q <= wdata;
                SEL_SRC:  src_q  <= wdata;
                SEL_POL:  pol_q  <= wdata;
                SEL_EDGE: edge_q <= wdata;
                SEL_SWI:  swi_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Produce the one-cycle clear vector from a write to the clear word.
    always_comb begin
        clr_pulse = '0;
        if (wr && hit && (sel == SEL_CLEAR)) clr_pulse = wdata;
    end

    assign masked = raw_req & ~mask_q;

    // Select the read data for the addressed word.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (sel)
                SEL_MASK:  rdata = mask_q;
                SEL_SRC:   rdata = src_q;
                SEL_MSTAT: rdata = masked;
                SEL_RSTAT: rdata = raw_req;
                SEL_CLEAR: rdata = '0;
                SEL_POL:   rdata = pol_q;
                SEL_EDGE:  rdata = edge_q;
                SEL_SWI:   rdata = swi_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/xif_forwarder.sv
// Top level of the external interrupt forwarder.
// Path: synchroniser, then trigger detection and request latch, then
// masking onto the outputs. Assumes line_in is asynchronous to clk.
module xif_forwarder #(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] trig;
    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] clr_pulse;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] edge_q;
    logic [NUM_LINES-1:0] masked;

    xif_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (sync_lines)
    );

    xif_detect #(.WIDTH(NUM_LINES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_lines),
        .edge_sel (edge_q),
        .pol      (pol_q),
        .clr      (clr_pulse),
        .trig     (trig),
        .req_q    (req_q)
    );

    xif_regfile #(.WIDTH(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .raw_req   (req_q),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .edge_q    (edge_q),
        .clr_pulse (clr_pulse),
        .masked    (masked),
        .rdata     (bus_rdata)
    );

    assign irq_out = masked;

endmodule

// File: rtl/xif_forwarder_chk.sv
// Property checker for the forwarder, bound to the top module.
// It observes the request latch, the clear vector, the trigger vector,
// the mask and the outputs.
module xif_forwarder_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] mask_q,
    input logic [WIDTH-1:0] req_q,
    input logic [WIDTH-1:0] trig,
    input logic [WIDTH-1:0] clr,
    input logic [WIDTH-1:0] irq_out
);

    logic was_reset = 1'b0;

    // Note that the previous edge was a reset edge.
    always_ff @(posedge clk) was_reset <= !rst_n;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        was_reset |-> (mask_q == '1 && req_q == '0)); // R1

    AST_MASK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask_q) == '0); // R7

    AST_TRIGGER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(trig & ~clr)) |=> ((req_q & $past(trig & ~clr)) == $past(trig & ~clr))); // R2

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((req_q & $past(clr)) == '0)); // R5

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |=> (($past(req_q) & ~$past(clr) & ~req_q) == '0)); // R4

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~req_q)) |=> ((req_q & ~$past(req_q) & ~$past(trig)) == '0)); // R3

endmodule

bind xif_forwarder xif_forwarder_chk #(.WIDTH(NUM_LINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_q  (mask_q),
    .req_q   (req_q),
    .trig    (trig),
    .clr     (clr_pulse),
    .irq_out (irq_out)
);

// File: tb/xif_forwarder_bench.sv
`timescale 1ns/1ps
module xif_forwarder_bench;

    localparam int N = 32;
    localparam logic [4:0] A_MASK = 5'h00, A_SRC = 5'h04, A_MSTAT = 5'h08,
                           A_RSTAT = 5'h0C, A_CLR = 5'h10, A_POL = 5'h14,
                           A_EDGE = 5'h18, A_SWI = 5'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         bus_wr = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xif_forwarder u_xif_forwarder (
        .clk (clk), .rst_n (rst_n), .line_in (line_in), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_out (irq_out)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [N-1:0] pat_of(input int m);
        case (m)
            0: return 32'h8000_0001;
            1: return 32'h0F0F_3C81;
            2: return 32'hF0E1_0306;
            default: return 32'h5A5A_A5A5;
        endcase
    endfunction

    initial begin
        logic [N-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_MASK, rd);  check("R1 mask reset", rd, '1);
        bus_read(A_POL, rd);   check("R1 polarity reset", rd, '1);
        bus_read(A_EDGE, rd);  check("R1 edge reset", rd, '0);
        bus_read(A_SRC, rd);   check("R1 source reset", rd, '0);
        bus_read(A_SWI, rd);   check("R1 swint reset", rd, '0);
        bus_read(A_RSTAT, rd); check("R1 raw reset", rd, '0);
        check("R1 outputs reset", irq_out, '0);

        // R9 register map and read-back
        bus_write(A_SRC, 32'hA5C3_0F96);
        bus_write(A_SWI, 32'h0000_0102);
        bus_write(A_EDGE, 32'h1234_5678);
        bus_read(A_SRC, rd);  check("R9 source readback", rd, 32'hA5C3_0F96);
        bus_read(A_SWI, rd);  check("R9 swint readback", rd, 32'h0000_0102);
        bus_read(A_EDGE, rd); check("R9 edge readback", rd, 32'h1234_5678);
        bus_write(A_EDGE, '0);
        bus_write(A_CLR, '1);
        bus_write(A_RSTAT, '1);
        bus_write(A_MSTAT, '1);
        bus_read(A_RSTAT, rd); check("R9 raw status not writable", rd, '0);
        bus_read(A_CLR, rd);   check("R9 clear reads zero", rd, '0);
        bus_write(5'h05, 32'h0);
        bus_read(A_MASK, rd);  check("R9 misaligned write ignored", rd, '1);
        bus_read(5'h01, rd);   check("R9 misaligned read zero", rd, '0);

        // R10 latency in level-high mode
        line_in = 32'h0000_0010;
        @(negedge clk); @(negedge clk);
        bus_read(A_RSTAT, rd); check("R10 not yet after two edges", rd, '0);
        @(negedge clk);
        bus_read(A_RSTAT, rd); check("R10 set on third edge", rd, 32'h0000_0010);
        line_in = '0;
        cycles(3);
        bus_write(A_CLR, '1);

        // Sweep all trigger modes: m[1] = edge, m[0] = polarity
        for (int m = 0; m < 4; m++) begin
            logic [N-1:0] pat, inact, act;
            bit is_edge;
            is_edge = m[1];
            pat   = pat_of(m);
            inact = m[0] ? '0 : '1;
            act   = inact ^ pat;
            bus_write(A_EDGE, is_edge ? '1 : '0);
            bus_write(A_POL, m[0] ? '1 : '0);
            line_in = inact;
            cycles(4);
            bus_write(A_CLR, '1);
            bus_read(A_RSTAT, rd); check($sformatf("R2 R3 idle m%0d", m), rd, '0);

            // Short pulse, then sticky (R2/R3/R4), masked (R7)
            @(negedge clk); line_in = act;
            @(negedge clk); line_in = inact;
            cycles(5);
            bus_read(A_RSTAT, rd); check($sformatf("R4 pulse latched m%0d", m), rd, pat);
            check($sformatf("R7 masked output low m%0d", m), irq_out, '0);
            bus_read(A_MSTAT, rd); check($sformatf("R8 masked status m%0d", m), rd, '0);

            // R8 partial unmask
            bus_write(A_MASK, ~32'h00FF_00FF);
            check($sformatf("R8 outputs m%0d", m), irq_out, pat & 32'h00FF_00FF);
            bus_read(A_MSTAT, rd); check($sformatf("R8 status m%0d", m), rd, pat & 32'h00FF_00FF);
            bus_write(A_MASK, '1);
            check($sformatf("R7 remask m%0d", m), irq_out, '0);

            // R5 write-one-to-clear
            bus_write(A_CLR, 32'h0000_FFFF);
            bus_read(A_RSTAT, rd); check($sformatf("R5 partial clear m%0d", m), rd, pat & 32'hFFFF_0000);
            bus_write(A_CLR, '0);
            bus_read(A_RSTAT, rd); check($sformatf("R5 zero write m%0d", m), rd, pat & 32'hFFFF_0000);
            bus_write(A_CLR, '1);

            // Held active then cleared: R6 for level, R3 for edge
            line_in = act;
            cycles(4);
            bus_write(A_CLR, '1);
            bus_read(A_RSTAT, rd); check($sformatf("R6 dip after clear m%0d", m), rd, '0);
            @(negedge clk);
            bus_read(A_RSTAT, rd);
            check($sformatf("%s held level m%0d", is_edge ? "R3" : "R6", m), rd, is_edge ? '0 : pat);
            cycles(3);
            bus_read(A_RSTAT, rd);
            check($sformatf("%s later m%0d", is_edge ? "R3" : "R6", m), rd, is_edge ? '0 : pat);
            line_in = inact;
            cycles(4);
            bus_write(A_CLR, '1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule